// File: doc/BRIEF.md
# Indirect Pattern Detector

This block watches index values that a load instruction brings back and the cache misses that follow, and looks for the relation `miss = base + scale(index)`. The scale is one of a fixed list of shifts, and all of them are tried at once. A small associative table holds one entry per prefetch-table stream, tagged by that stream's identifier. The first index seen for a stream is held as the *first index*. For each of the next few misses, the block stores one candidate base address per shift.

When the same stream reports a *second index*, each later miss is turned into candidate bases with the second index. These are compared with every recorded candidate. A base counts as confirmed only when two different index values lead to the same base under the same shift. The block then emits a one-cycle pattern report (stream tag, base, shift) to the downstream confidence logic and frees the entry. Only one entry follows misses at any time. A `tracking` output tells the cache when misses should be sent to the block.

Top module: `idp_top`

## Requirements
- R1: After synchronous reset, `tracking` and `found_valid` are 0, every entry is free, and all stored candidates are zero.
- R2: An index observation whose tag matches no valid entry allocates an entry: a free one first, else the least recently used. The value is stored as the first index, the entry becomes the tracker, and `tracking` is 1 from the next cycle.
- R3: While the tracker holds only a first index, each miss stores `miss - scale_s(first)` for all four shifts into the next free slot, where `scale_s` is left shift by s for s = 2, 3, 4 and arithmetic right shift by 3 for s = -3. After the fourth recorded miss, `tracking` drops to 0.
- R4: An index observation that hits an entry holding only a first index stores it as the second index and makes that entry the tracker. `tracking` is 1 from the next cycle.
- R5: While the tracker holds a second index, a miss whose `miss - scale_s(second)` equals a recorded candidate for the same shift raises `found_valid` for exactly the next cycle, with the entry's tag, the base and the shift (signed, one of 2, 3, 4, -3). The entry is freed and `tracking` drops, so the next index with that tag allocates afresh.
- R6: When several candidates match, the lowest slot wins, and within a slot the shift order 2, 3, 4, -3 decides.
- R7: An index observation that hits an entry already holding a second index frees that entry and clears `tracking`, with no report.
- R8: A miss while `tracking` is 0 produces no report and changes no stored state.
- R9: When a miss and an index observation arrive in the same cycle while `tracking` is 1, the miss is processed and the index observation is ignored.
- R10: Every index observation that hits or allocates an entry makes that entry the most recently used; misses do not change recency.
- R11: Only slots already recorded for the tracker take part in the comparison; stale or reset slot contents never produce a report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| idx_valid | input | 1 | Index observation present |
| idx_tag | input | TAG_W | Prefetch-table stream identifier |
| idx_value | input | IDX_W | Loaded index, two's complement |
| miss_valid | input | 1 | Cache miss present |
| miss_addr | input | ADDR_W | Miss address |
| tracking | output | 1 | An entry currently follows misses |
| found_valid | output | 1 | One-cycle pattern report |
| found_tag | output | TAG_W | Stream tag of the confirmed pattern |
| found_base | output | ADDR_W | Confirmed base address |
| found_shift | output | 4 | Confirmed shift, signed |

## Verification
A wrong slot counter or a lost first index shows up at the ports only later: `tracking` drops one miss too early or too late, or a report arrives with the wrong base or no report arrives at all. Stale candidate data or wrong replacement choices can stay hidden until a second index is confirmed, or until a third index frees the wrong stream. For that reason the bench compares `tracking` and the report outputs against a behavioural model on every cycle. The error then surfaces within one cycle of the first observable divergence and is not left to a final check.

// File: rtl/idp_pkg.sv
package idp_pkg;
    localparam int NSHIFT = 4;
    localparam int SHIFT_W = 4;

    // Shift list in priority order; negative means arithmetic right shift.
    function automatic int shift_of(input int k);
        case (k)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            default: return -3;
        endcase
    endfunction

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_INDEX = 2'd1,
        OP_MISS  = 2'd2
    } op_e;
endpackage

// File: rtl/idp_lru.sv
module idp_lru #(
    parameter int N = 4,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           touch,
    input  logic [IDW-1:0] touch_id,
    input  logic [N-1:0]   used,
    output logic [IDW-1:0] victim
);
    logic [IDW-1:0] rank [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) rank[i] <= IDW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IDW'(i) == touch_id)
                    rank[i] <= '0;
                else if (rank[i] < rank[touch_id])
                    rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic got_free;
        got_free = 1'b0;
        victim   = '0;
        for (int i = 0; i < N; i++)
            if (rank[i] == IDW'(N - 1)) victim = IDW'(i);
        for (int i = 0; i < N; i++)
            if (!used[i] && !got_free) begin
                victim   = IDW'(i);
                got_free = 1'b1;
            end
    end
endmodule

// File: rtl/idp_match.sv
module idp_match
    import idp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int SLOTS  = 4,
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic signed [IDX_W-1:0] idx,
    input  logic [ADDR_W-1:0]       miss_addr,
    input  logic [ADDR_W-1:0]       cand [SLOTS][NSHIFT],
    input  logic [CW-1:0]           nrec,
    output logic [ADDR_W-1:0]       fresh [NSHIFT],
    output logic                    hit,
    output logic [ADDR_W-1:0]       hit_base,
    output logic signed [SHIFT_W-1:0] hit_shift
);
    logic [ADDR_W-1:0] sext;
    assign sext = {{(ADDR_W-IDX_W){idx[IDX_W-1]}}, idx};

    for (genvar k = 0; k < NSHIFT; k++) begin : g_scale
        localparam int SH = shift_of(k);
        logic [ADDR_W-1:0] scaled;
        if (SH >= 0) begin : g_left
            assign scaled = sext << SH;
        end else begin : g_right
            assign scaled = ADDR_W'($signed(sext) >>> (-SH));
        end
        assign fresh[k] = miss_addr - scaled;
    end

    // Walk from lowest priority to highest so the earliest match wins.
    always_comb begin
        hit       = 1'b0;
        hit_base  = '0;
        hit_shift = '0;
        for (int j = SLOTS - 1; j >= 0; j--) begin
            for (int k = NSHIFT - 1; k >= 0; k--) begin
                if (CW'(j) < nrec && cand[j][k] == fresh[k]) begin
                    hit       = 1'b1;
                    hit_base  = cand[j][k];
                    hit_shift = SHIFT_W'(shift_of(k));
                end
            end
        end
    end
endmodule

// File: rtl/idp_top.sv
module idp_top
    import idp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 16,
    parameter int TAG_W   = 4,
    parameter int ENTRIES = 4,
    parameter int SLOTS   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      idx_valid,
    input  logic [TAG_W-1:0]          idx_tag,
    input  logic [IDX_W-1:0]          idx_value,
    input  logic                      miss_valid,
    input  logic [ADDR_W-1:0]         miss_addr,
    output logic                      tracking,
    output logic                      found_valid,
    output logic [TAG_W-1:0]          found_tag,
    output logic [ADDR_W-1:0]         found_base,
    output logic signed [SHIFT_W-1:0] found_shift
);
    localparam int IDW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CW  = $clog2(SLOTS + 1);
    localparam int SW  = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [ENTRIES-1:0] e_used, e_second;
    logic [TAG_W-1:0]   e_tag   [ENTRIES];
    logic [IDX_W-1:0]   e_first [ENTRIES];
    logic [IDX_W-1:0]   e_sec   [ENTRIES];
    logic [CW-1:0]      e_nrec  [ENTRIES];
    logic [ADDR_W-1:0]  e_cand  [ENTRIES][SLOTS][NSHIFT];

    logic           trk_on;
    logic [IDW-1:0] trk_id;

    op_e            op;
    logic           tag_hit;
    logic [IDW-1:0] hit_id, victim;

    always_comb begin
        tag_hit = 1'b0;
        hit_id  = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (e_used[i] && e_tag[i] == idx_tag) begin
                tag_hit = 1'b1;
                hit_id  = IDW'(i);
            end
    end

    always_comb begin
        if (miss_valid && trk_on) op = OP_MISS;
        else if (idx_valid)       op = OP_INDEX;
        else                      op = OP_NONE;
    end

    idp_lru #(.N(ENTRIES)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .touch    (op == OP_INDEX),
        .touch_id (tag_hit ? hit_id : victim),
        .used     (e_used),
        .victim   (victim)
    );

    logic [ADDR_W-1:0]         fresh [NSHIFT];
    logic                      m_hit;
    logic [ADDR_W-1:0]         m_base;
    logic signed [SHIFT_W-1:0] m_shift;

    idp_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOTS(SLOTS)) u_match (
        .idx       (e_second[trk_id] ? e_sec[trk_id] : e_first[trk_id]),
        .miss_addr (miss_addr),
        .cand      (e_cand[trk_id]),
        .nrec      (e_nrec[trk_id]),
        .fresh     (fresh),
        .hit       (m_hit),
        .hit_base  (m_base),
        .hit_shift (m_shift)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            e_used      <= '0;
            e_second    <= '0;
            trk_on      <= 1'b0;
            trk_id      <= '0;
            found_valid <= 1'b0;
            found_tag   <= '0;
            found_base  <= '0;
            found_shift <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                e_tag[i]   <= '0;
                e_first[i] <= '0;
                e_sec[i]   <= '0;
                e_nrec[i]  <= '0;
                for (int j = 0; j < SLOTS; j++)
                    for (int k = 0; k < NSHIFT; k++)
                        e_cand[i][j][k] <= '0;
            end
        end else begin
            found_valid <= 1'b0;
            case (op)
                OP_MISS: begin
                    if (!e_second[trk_id]) begin
                        for (int k = 0; k < NSHIFT; k++)
                            e_cand[trk_id][SW'(e_nrec[trk_id])][k] <= fresh[k];
                        e_nrec[trk_id] <= e_nrec[trk_id] + 1'b1;
                        if (e_nrec[trk_id] == CW'(SLOTS - 1)) trk_on <= 1'b0;
                    end else if (m_hit) begin
                        found_valid      <= 1'b1;
                        found_tag        <= e_tag[trk_id];
                        found_base       <= m_base;
                        found_shift      <= m_shift;
                        e_used[trk_id]   <= 1'b0;
                        e_second[trk_id] <= 1'b0;
                        trk_on           <= 1'b0;
                    end
                end
                OP_INDEX: begin
                    if (tag_hit) begin
                        if (!e_second[hit_id]) begin
                            e_sec[hit_id]    <= idx_value;
                            e_second[hit_id] <= 1'b1;
                            trk_on           <= 1'b1;
                            trk_id           <= hit_id;
                        end else begin
                            e_used[hit_id]   <= 1'b0;
                            e_second[hit_id] <= 1'b0;
                            trk_on           <= 1'b0;
                        end
                    end else begin
                        e_used[victim]   <= 1'b1;
                        e_second[victim] <= 1'b0;
                        e_tag[victim]    <= idx_tag;
                        e_first[victim]  <= idx_value;
                        e_nrec[victim]   <= '0;
                        trk_on           <= 1'b1;
                        trk_id           <= victim;
                    end
                end
                default: ;
            endcase
        end
    end

    assign tracking = trk_on;
endmodule

// File: rtl/idp_top_chk.sv
module idp_top_chk
    import idp_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      miss_valid,
    input logic                      tracking,
    input logic                      found_valid,
    input logic signed [SHIFT_W-1:0] found_shift
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tracking && !found_valid));

    a_r5_report_ends_tracking: assert property (@(posedge clk) disable iff (rst)
        found_valid |-> !tracking);

    a_r5_report_one_cycle: assert property (@(posedge clk) disable iff (rst)
        found_valid |=> !found_valid);

    a_r8_idle_miss_no_report: assert property (@(posedge clk) disable iff (rst)
        !(miss_valid && tracking) |=> !found_valid);

    a_r6_shift_legal: assert property (@(posedge clk) disable iff (rst)
        found_valid |-> (found_shift == 4'sd2 || found_shift == 4'sd3 ||
                         found_shift == 4'sd4 || found_shift == -4'sd3));
endmodule

bind idp_top idp_top_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .miss_valid  (miss_valid),
    .tracking    (tracking),
    .found_valid (found_valid),
    .found_shift (found_shift)
);

// File: tb/tb_idp_top.sv
`timescale 1ns/1ps
module tb_idp_top;
    localparam int AW = 32, IW = 16, TW = 4, NE = 4, NS = 4;
    localparam longint MASK = 64'hFFFF_FFFF;

    logic clk = 0, rst = 1;
    logic idx_valid = 0, miss_valid = 0;
    logic [TW-1:0] idx_tag = 0;
    logic [IW-1:0] idx_value = 0;
    logic [AW-1:0] miss_addr = 0;
    logic tracking, found_valid;
    logic [TW-1:0] found_tag;
    logic [AW-1:0] found_base;
    logic signed [3:0] found_shift;

    always #2.5 clk = ~clk;

    idp_top dut (.*);

    int checks = 0, errors = 0;
    string req = "R1";

    // Behavioural reference state
    bit     m_used [NE];
    bit     m_sec  [NE];
    int     m_tag  [NE];
    int     m_i1   [NE];
    int     m_i2   [NE];
    int     m_nrec [NE];
    longint m_cand [NE][NS][4];
    int     order [$];
    bit     m_trk;
    int     m_trk_id;
    bit     x_found;
    int     x_tag, x_shift;
    longint x_base;

    function automatic int sh_of(int k);
        int t[4] = '{2, 3, 4, -3};
        return t[k];
    endfunction

    function automatic longint base_of(longint miss, int idx, int sh);
        longint sc;
        sc = (sh >= 0) ? (longint'(idx) <<< sh) : (longint'(idx) >>> (-sh));
        return (miss - sc) & MASK;
    endfunction

    task automatic model_reset();
        order = {};
        for (int i = 0; i < NE; i++) begin
            m_used[i] = 0; m_sec[i] = 0; m_tag[i] = 0; m_i1[i] = 0;
            m_i2[i] = 0; m_nrec[i] = 0; order.push_back(i);
            for (int j = 0; j < NS; j++)
                for (int k = 0; k < 4; k++) m_cand[i][j][k] = 0;
        end
        m_trk = 0; m_trk_id = 0; x_found = 0;
    endtask

    task automatic touch(int id);
        foreach (order[q]) if (order[q] == id) begin order.delete(q); break; end
        order.push_front(id);
    endtask

    task automatic model_step(bit iv, int tg, int iv_val, bit mv, longint ma);
        x_found = 0;
        if (mv && m_trk) begin
            int t = m_trk_id;
            if (!m_sec[t]) begin
                for (int k = 0; k < 4; k++) m_cand[t][m_nrec[t]][k] = base_of(ma, m_i1[t], sh_of(k));
                m_nrec[t]++;
                if (m_nrec[t] == NS) m_trk = 0;
            end else begin
                bit done = 0;
                for (int j = 0; j < m_nrec[t] && !done; j++)
                    for (int k = 0; k < 4 && !done; k++)
                        if (m_cand[t][j][k] == base_of(ma, m_i2[t], sh_of(k))) begin
                            done = 1; x_found = 1; x_tag = m_tag[t];
                            x_base = m_cand[t][j][k]; x_shift = sh_of(k);
                        end
                if (done) begin m_used[t] = 0; m_sec[t] = 0; m_trk = 0; end
            end
        end else if (iv) begin
            int h = -1, v = -1;
            for (int i = 0; i < NE; i++) if (m_used[i] && m_tag[i] == tg) h = i;
            if (h >= 0) begin
                touch(h);
                if (!m_sec[h]) begin
                    m_i2[h] = iv_val; m_sec[h] = 1; m_trk = 1; m_trk_id = h;
                end else begin
                    m_used[h] = 0; m_sec[h] = 0; m_trk = 0;
                end
            end else begin
                for (int i = NE - 1; i >= 0; i--) if (!m_used[i]) v = i;
                if (v < 0) v = order[$];
                touch(v);
                m_used[v] = 1; m_sec[v] = 0; m_tag[v] = tg; m_i1[v] = iv_val;
                m_nrec[v] = 0; m_trk = 1; m_trk_id = v;
            end
        end
    endtask

    task automatic chk(bit ok, string r, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(tracking == m_trk, req, "tracking", tracking, m_trk);
        chk(found_valid == x_found, req, "found_valid", found_valid, x_found);
        if (x_found && found_valid) begin
            chk(found_base == AW'(x_base), req, "found_base", found_base, x_base);
            chk(int'(found_shift) == x_shift, req, "found_shift", found_shift, x_shift);
            chk(int'(found_tag) == x_tag, req, "found_tag", found_tag, x_tag);
        end
    endtask

    task automatic step(bit iv, int tg, int val, bit mv, longint ma);
        @(negedge clk);
        idx_valid = iv; idx_tag = TW'(tg); idx_value = IW'(val);
        miss_valid = mv; miss_addr = AW'(ma);
        model_step(iv, tg, longint'($signed(IW'(val))), mv, ma & MASK);
        @(posedge clk); #1;
        compare();
    endtask

    task automatic idx(int tg, int val); step(1, tg, val, 0, 0); endtask
    task automatic miss(longint a); step(0, 0, 0, 1, a); endtask

    initial begin
        fork
            begin
                model_reset();
                repeat (3) @(posedge clk);
                @(negedge clk); rst = 0;
                #1;
                req = "R1";
                chk(tracking == 0, "R1", "tracking after reset", tracking, 0);
                chk(found_valid == 0, "R1", "found after reset", found_valid, 0);

                // R11: no recorded slots, reset contents must not match
                req = "R11";
                idx(9, 3); idx(9, 5);
                miss(5 << 2);
                chk(found_valid == 0, "R11", "unrecorded slot hit", found_valid, 0);
                req = "R7";
                idx(9, 1);
                chk(tracking == 0, "R7", "third index frees", tracking, 0);

                // R2, R3, R8: record four misses, tracking stops
                req = "R2"; idx(1, 10);
                chk(tracking == 1, "R2", "allocate starts tracking", tracking, 1);
                req = "R3";
                miss(32'h1050); miss(32'h2000); miss(32'h3000); miss(32'h4000);
                chk(tracking == 0, "R3", "stop after four misses", tracking, 0);
                req = "R8"; miss(32'h10A0);
                chk(found_valid == 0, "R8", "idle miss ignored", found_valid, 0);

                // R4, R5: second index confirms base 0x1000, shift 3
                req = "R4"; idx(1, 20);
                chk(tracking == 1, "R4", "second index tracks", tracking, 1);
                req = "R5"; miss(32'h10A0);
                chk(found_valid && found_base == 32'h1000 && found_shift == 3,
                    "R5", "confirmed base", found_base, 32'h1000);
                idx(1, 7);
                chk(tracking == 1, "R5", "freed tag reallocates", tracking, 1);
                idx(1, 9);
                req = "R7"; idx(1, 11);
                chk(tracking == 0, "R7", "third index clears", tracking, 0);

                // R6: negative shift
                req = "R6";
                idx(2, 64); miss(32'h8008); idx(2, 128); miss(32'h8010);
                chk(found_valid && found_base == 32'h8000 && found_shift == -3,
                    "R6", "negative shift base", found_base, 32'h8000);
                // R6: lowest slot wins over earlier shift
                idx(3, 4); miss(32'h1E0); miss(32'h210); idx(3, 8); miss(32'h220);
                chk(found_valid && found_base == 32'h1A0 && found_shift == 4,
                    "R6", "slot priority", found_base, 32'h1A0);

                // R9: miss and index together while tracking
                req = "R9";
                idx(5, 2);
                step(1, 5, 6, 1, 32'h900);
                idx(5, 6);
                chk(tracking == 1, "R9", "index ignored during miss", tracking, 1);

                // R10: recency order picks the victim
                req = "R10";
                idx(10, 1); idx(11, 1); idx(12, 1); idx(13, 1);
                idx(10, 2);
                idx(14, 1);
                idx(10, 3);
                chk(tracking == 0, "R10", "recent entry kept", tracking, 0);

                // Mixed random traffic against the model
                req = "R5";
                for (int n = 0; n < 4000; n++) begin
                    int vals[6] = '{1, 2, 3, 8, 16, -8};
                    int pick = $urandom_range(0, 9);
                    int v = vals[$urandom_range(0, 5)];
                    longint b = ($urandom_range(0, 1) != 0) ? 64'h100 : 64'h200;
                    longint a = base_of(b, -v, sh_of($urandom_range(0, 3)));
                    if (pick < 3)      step(1, $urandom_range(0, 5), v, 0, 0);
                    else if (pick < 9) step(0, 0, 0, 1, a);
                    else               step(1, $urandom_range(0, 5), v, 1, a);
                end
            end
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule